// File: doc/BRIEF.md
# X-Tolerant Weighted-Code Signature Compactor

This block folds the parallel outputs of several scan chains into one fixed-width signature. On every valid shift cycle a pseudo-random sparse linear code decides which signature bits each scan bit feeds. The code comes from an on-chip LFSR whose state is spread by a fixed phase-shifter network. The selected bits are XOR-accumulated into the signature. Signature bits never shift into each other and have no feedback path. An unknown scan value therefore spoils only the signature bits that its code entries pick, and a tester can still compare every other bit.

All pseudo-random mixing takes place in the code path, before data meets the signature. Each code entry is the AND of k pseudo-random bits, so one input reaches one signature bit with probability 2^-k. A weight selector chooses k. A programmable block length sets how many valid cycles go into each signature. After a signature is emitted, accumulation restarts for the next block without losing a cycle.

The LFSR runs on across blocks and across repeated runs of a test pattern. Running the same pattern again therefore samples a fresh code. A synchronous seed load makes the whole code sequence reproducible, so an offline model can rebuild the code matrix for diagnosis.

Top module: `xwc_compactor`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `sig` is all zeros and `sig_vld` is 0. The LFSR state is the parameter `RST_SEED` (default 32'h1ACEB00C).
- R2: The effective weight k is `weight_sel` clamped to the range 3..6. The code entry for chain i and signature bit b is the AND of the phase bits p(j) for j = (i*SIG_W+b)*6+m, with m from 0 to k-1. For LFSR state S of width L, p(j) = S[j%L] ^ S[(j/L+7j+1)%L] ^ S[(3(j/L)+13j+5)%L].
- R3: On a cycle with `scan_vld` high, signature bit b is XORed with the parity of the scan bits i whose entry (i,b) is set. The code is computed from the LFSR state held before that clock edge. No signature bit depends on another signature bit.
- R4: Inverting a single scan bit in one cycle of a block changes the emitted signature in exactly the bits selected by that input's code entries in that cycle.
- R5: A signature is emitted after `blk_len` valid cycles, and a `blk_len` of 0 counts as 1. `sig_vld` is high for the cycle after the clock edge that took the block's last valid input. `sig` keeps its value until the next emission.
- R6: At emission the accumulator restarts from zero, and the next valid cycle's data is the first term of the next block. No input cycle is dropped.
- R7: The LFSR takes one Galois step per valid cycle: S' = (S>>1) ^ (S[0] ? POLY : 0), with POLY defaulting to 32'h80200003. A cycle with `scan_vld` low advances nothing, accumulates nothing and emits nothing.
- R8: `seed_ld` loads `seed` into the LFSR at the clock edge and overrides the step of that cycle. Data on that cycle is still coded with the old state. Loading the same seed and replaying the same data reproduces the same signature.
- R9: Without a seed load, replaying the same data uses the continuing LFSR sequence and gives the signature that sequence predicts.
- R10: If `blk_len` is lowered during a block to or below the number of valid cycles already taken, the next valid cycle closes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | CHAINS | One scan-out bit per chain |
| scan_vld | input | 1 | scan_in carries a response slice this cycle |
| seed_ld | input | 1 | Load `seed` into the code generator LFSR |
| seed | input | LFSR_W | Seed value (must be nonzero) |
| weight_sel | input | 3 | Requested AND depth k, clamped to 3..6 |
| blk_len | input | CNT_W | Valid cycles per signature (0 acts as 1) |
| sig | output | SIG_W | Last emitted signature |
| sig_vld | output | 1 | One-cycle strobe for a new signature |

## Verification
The bound checker checks on every cycle the properties that follow from port and LFSR timing alone. These are the reset values, signature hold between emissions, the freeze of the LFSR and the absence of emission on idle cycles, the seed load, and the emission after every valid cycle when a block is one cycle long. The code values, the parity accumulation, X containment, the zero restart after emission, replay after reseeding and the continuation of the sequence all depend on the exact code matrix. Only the bench's reference model can show these, because it recomputes the matrix behaviourally from the LFSR state in every cycle of each scenario.

// File: rtl/xwc_pkg.sv
package xwc_pkg;
  localparam int KMIN = 3;
  localparam int KMAX = 6;

  // phase-shifter tap positions for phase bit j over an LFSR of width l
  function automatic int tap_a(input int j, input int l);
    return j % l;
  endfunction

  function automatic int tap_b(input int j, input int l);
    return (j / l + 7 * j + 1) % l;
  endfunction

  function automatic int tap_c(input int j, input int l);
    return (3 * (j / l) + 13 * j + 5) % l;
  endfunction
endpackage

// File: rtl/xwc_lfsr.sv
module xwc_lfsr #(
  parameter int LFSR_W = 32,
  parameter logic [LFSR_W-1:0] POLY = 32'h80200003,
  parameter logic [LFSR_W-1:0] RST_SEED = 32'h1ACEB00C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              load,
  input  logic [LFSR_W-1:0] load_val,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] nxt;

  always_comb begin
    nxt = state >> 1;
    if (state[0]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= RST_SEED;
    else if (load) state <= load_val;
    else if (adv)  state <= nxt;
  end
endmodule

// File: rtl/xwc_code_gen.sv
module xwc_code_gen #(
  parameter int CHAINS = 4,
  parameter int SIG_W  = 32,
  parameter int LFSR_W = 32
) (
  input  logic [LFSR_W-1:0]       state,
  input  logic [2:0]              k_eff,
  output logic [CHAINS*SIG_W-1:0] code
);
  import xwc_pkg::*;

  logic [KMAX-1:0] en;

  always_comb begin
    for (int m = 0; m < KMAX; m++) en[m] = (m < int'(k_eff));
  end

  for (genvar gi = 0; gi < CHAINS; gi++) begin : g_chain
    for (genvar gb = 0; gb < SIG_W; gb++) begin : g_bit
      logic [KMAX-1:0] pv;
      for (genvar gm = 0; gm < KMAX; gm++) begin : g_term
        localparam int J  = (gi * SIG_W + gb) * KMAX + gm;
        localparam int TA = tap_a(J, LFSR_W);
        localparam int TB = tap_b(J, LFSR_W);
        localparam int TC = tap_c(J, LFSR_W);
        assign pv[gm] = state[TA] ^ state[TB] ^ state[TC];
      end
      assign code[gi*SIG_W+gb] = &(pv | ~en);
    end
  end
endmodule

// File: rtl/xwc_accum.sv
module xwc_accum #(
  parameter int CHAINS = 4,
  parameter int SIG_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scan_vld,
  input  logic [CHAINS-1:0]       scan_in,
  input  logic [CHAINS*SIG_W-1:0] code,
  input  logic [CNT_W-1:0]        blk_len,
  output logic [SIG_W-1:0]        sig,
  output logic                    sig_vld
);
  logic [SIG_W-1:0] acc_q;
  logic [SIG_W-1:0] contrib;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   len_eff;
  logic             last;

  always_comb begin
    for (int b = 0; b < SIG_W; b++) begin
      contrib[b] = 1'b0;
      for (int i = 0; i < CHAINS; i++)
        contrib[b] = contrib[b] ^ (scan_in[i] & code[i*SIG_W+b]);
    end
  end

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    len_eff = (blk_len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, blk_len};
    last    = (cnt_inc >= len_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      sig     <= '0;
      sig_vld <= 1'b0;
    end else begin
      sig_vld <= 1'b0;
      if (scan_vld) begin
        if (last) begin
          sig     <= acc_q ^ contrib;
          sig_vld <= 1'b1;
          acc_q   <= '0;
          cnt_q   <= '0;
        end else begin
          acc_q <= acc_q ^ contrib;
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/xwc_compactor.sv
module xwc_compactor #(
  parameter int CHAINS = 4,
  parameter int SIG_W  = 32,
  parameter int LFSR_W = 32,
  parameter int CNT_W  = 16,
  parameter logic [LFSR_W-1:0] POLY = 32'h80200003,
  parameter logic [LFSR_W-1:0] RST_SEED = 32'h1ACEB00C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAINS-1:0] scan_in,
  input  logic              scan_vld,
  input  logic              seed_ld,
  input  logic [LFSR_W-1:0] seed,
  input  logic [2:0]        weight_sel,
  input  logic [CNT_W-1:0]  blk_len,
  output logic [SIG_W-1:0]  sig,
  output logic              sig_vld
);
  import xwc_pkg::*;

  logic [LFSR_W-1:0]       lfsr_q;
  logic [CHAINS*SIG_W-1:0] code;
  logic [2:0]              k_eff;

  always_comb begin
    if (weight_sel < 3'(KMIN))      k_eff = 3'(KMIN);
    else if (weight_sel > 3'(KMAX)) k_eff = 3'(KMAX);
    else                            k_eff = weight_sel;
  end

  xwc_lfsr #(.LFSR_W(LFSR_W), .POLY(POLY), .RST_SEED(RST_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(scan_vld), .load(seed_ld),
    .load_val(seed), .state(lfsr_q)
  );

  xwc_code_gen #(.CHAINS(CHAINS), .SIG_W(SIG_W), .LFSR_W(LFSR_W)) u_code (
    .state(lfsr_q), .k_eff(k_eff), .code(code)
  );

  xwc_accum #(.CHAINS(CHAINS), .SIG_W(SIG_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .scan_vld(scan_vld), .scan_in(scan_in),
    .code(code), .blk_len(blk_len), .sig(sig), .sig_vld(sig_vld)
  );
endmodule

// File: rtl/xwc_compactor_chk.sv
module xwc_compactor_chk #(
  parameter int SIG_W  = 32,
  parameter int LFSR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_vld,
  input logic              seed_ld,
  input logic [LFSR_W-1:0] seed,
  input logic [CNT_W-1:0]  blk_len,
  input logic [SIG_W-1:0]  sig,
  input logic              sig_vld,
  input logic [LFSR_W-1:0] lfsr_q
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst) begin
      // R1
      reset_state_chk: assert (sig == '0 && !sig_vld);
    end
  end

  // R5
  sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sig_vld |-> $stable(sig));

  // R7
  idle_lfsr_chk: assert property (@(posedge clk) disable iff (rst)
    (!scan_vld && !seed_ld) |=> $stable(lfsr_q));

  // R7
  idle_emit_chk: assert property (@(posedge clk) disable iff (rst)
    !scan_vld |=> !sig_vld);

  // R8
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    seed_ld |=> (lfsr_q == $past(seed)));

  // R5
  unit_block_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_vld && blk_len <= CNT_W'(1)) |=> sig_vld);
endmodule

bind xwc_compactor xwc_compactor_chk #(
  .SIG_W(SIG_W), .LFSR_W(LFSR_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst(rst), .scan_vld(scan_vld), .seed_ld(seed_ld),
  .seed(seed), .blk_len(blk_len), .sig(sig), .sig_vld(sig_vld),
  .lfsr_q(lfsr_q)
);

// File: tb/test_xwc_compactor.sv
module test_xwc_compactor;
  localparam int CH = 4;
  localparam int SW = 32;
  localparam int LW = 32;
  localparam int CW = 16;
  localparam logic [LW-1:0] POLY = 32'h80200003;
  localparam logic [LW-1:0] RSEED = 32'h1ACEB00C;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CH-1:0] scan_in = '0;
  logic scan_vld = 1'b0;
  logic seed_ld = 1'b0;
  logic [LW-1:0] seed = '0;
  logic [2:0] weight_sel = 3'd5;
  logic [CW-1:0] blk_len = 16'd4;
  logic [SW-1:0] sig;
  logic sig_vld;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [LW-1:0] m_lfsr;
  logic [SW-1:0] m_acc, m_sig;
  logic m_vld;
  int m_cnt;
  logic [31:0] rng = 32'h2468ACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xwc_compactor i_xwc_compactor (
    .clk(clk), .rst(rst), .scan_in(scan_in), .scan_vld(scan_vld),
    .seed_ld(seed_ld), .seed(seed), .weight_sel(weight_sel),
    .blk_len(blk_len), .sig(sig), .sig_vld(sig_vld)
  );

  function automatic logic [31:0] rnd();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng;
  endfunction

  function automatic logic [LW-1:0] gstep(input logic [LW-1:0] s);
    logic [LW-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ POLY;
    return n;
  endfunction

  function automatic int kclamp(input logic [2:0] w);
    if (w < 3) return 3;
    if (w > 6) return 6;
    return int'(w);
  endfunction

  function automatic bit entry(input logic [LW-1:0] s, input int i, input int b, input int k);
    for (int m = 0; m < k; m++) begin
      int j;
      bit p;
      j = (i * SW + b) * 6 + m;
      p = s[j % LW] ^ s[(j / LW + 7 * j + 1) % LW] ^ s[(3 * (j / LW) + 13 * j + 5) % LW];
      if (!p) return 0;
    end
    return 1;
  endfunction

  function automatic logic [SW-1:0] row(input logic [LW-1:0] s, input int i, input int k);
    logic [SW-1:0] r;
    for (int b = 0; b < SW; b++) r[b] = entry(s, i, b, k);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lfsr = RSEED; m_acc = '0; m_sig = '0; m_vld = 1'b0; m_cnt = 0;
  endtask

  // drive one cycle at negedge, update model, compare at next negedge
  task automatic cyc(input logic v, input logic [CH-1:0] d, input logic ld,
                     input logic [LW-1:0] sd, input string tag);
    int k, len;
    logic [SW-1:0] c;
    scan_vld = v; scan_in = d; seed_ld = ld; seed = sd;
    k = kclamp(weight_sel);
    len = (blk_len == 0) ? 1 : int'(blk_len);
    m_vld = 1'b0;
    if (v) begin
      c = '0;
      for (int i = 0; i < CH; i++) if (d[i]) c = c ^ row(m_lfsr, i, k);
      if (m_cnt + 1 >= len) begin
        m_sig = m_acc ^ c; m_vld = 1'b1; m_acc = '0; m_cnt = 0;
      end else begin
        m_acc = m_acc ^ c; m_cnt++;
      end
    end
    if (ld) m_lfsr = sd;
    else if (v) m_lfsr = gstep(m_lfsr);
    @(posedge clk);
    @(negedge clk);
    check({tag, " sig"}, 64'(sig), 64'(m_sig));
    check({tag, " sig_vld"}, 64'(sig_vld), 64'(m_vld));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] dv [8];
    logic [SW-1:0] sa, sb;
    logic [LW-1:0] st;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 sig", 64'(sig), 64'd0);
    check("R1 sig_vld", 64'(sig_vld), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 64'({sig, sig_vld}), 64'd0);

    // R7: idle cycles change nothing
    for (int t = 0; t < 3; t++) cyc(1'b0, CH'(rnd()), 1'b0, '0, "R7 idle");

    // R2, R3: every weight setting including clamped ones
    for (int w = 0; w < 8; w++) begin
      weight_sel = 3'(w); blk_len = 16'd4;
      for (int t = 0; t < 8; t++) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R2 R3 weight");
    end

    // R5: zero and unit block length
    weight_sel = 3'd4; blk_len = 16'd0;
    for (int t = 0; t < 4; t++) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R5 len0");
    blk_len = 16'd1;
    for (int t = 0; t < 3; t++) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R5 len1");

    // R6, R7: back-to-back blocks with idle gaps
    blk_len = 16'd6;
    for (int t = 0; t < 30; t++) begin
      logic [31:0] r;
      r = rnd();
      cyc(r[16] | r[17], CH'(r >> 4), 1'b0, '0, "R6 R7 gaps");
    end
    for (int t = 0; t < 12; t++) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R6 restart");
    // finish any open block
    while (m_cnt != 0) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R6 drain");

    // R10: shorten the block mid-way
    blk_len = 16'd8;
    for (int t = 0; t < 5; t++) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R10 pre");
    blk_len = 16'd3;
    cyc(1'b1, CH'(rnd()), 1'b0, '0, "R10 shorten");
    check("R10 emit now", 64'(sig_vld), 64'd1);

    // R4, R8, R9: replay experiments
    weight_sel = 3'd5; blk_len = 16'd8;
    for (int t = 0; t < 8; t++) dv[t] = CH'(rnd());
    cyc(1'b0, '0, 1'b1, 32'hC0FFEE11, "R8 load");
    for (int t = 0; t < 8; t++) cyc(1'b1, dv[t], 1'b0, '0, "R8 run A");
    sa = sig;
    cyc(1'b0, '0, 1'b1, 32'hC0FFEE11, "R8 reload");
    for (int t = 0; t < 8; t++)
      cyc(1'b1, (t == 3) ? (dv[t] ^ CH'(4)) : dv[t], 1'b0, '0, "R4 run B");
    sb = sig;
    st = 32'hC0FFEE11;
    for (int t = 0; t < 3; t++) st = gstep(st);
    check("R4 flip diff", 64'(sa ^ sb), 64'(row(st, 2, 5)));
    cyc(1'b0, '0, 1'b1, 32'hC0FFEE11, "R8 reload2");
    for (int t = 0; t < 8; t++) cyc(1'b1, dv[t], 1'b0, '0, "R8 replay");
    check("R8 replay equal", 64'(sig), 64'(sa));
    for (int t = 0; t < 8; t++) cyc(1'b1, dv[t], 1'b0, '0, "R9 continue");

    // R8: load and valid on the same edge
    blk_len = 16'd2;
    cyc(1'b1, CH'(rnd()), 1'b1, 32'h5EED0001, "R8 load+vld");
    for (int t = 0; t < 5; t++) cyc(1'b1, CH'(rnd()), 1'b0, '0, "R8 after load");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule